// File: doc/BRIEF.md
# Floppy Controller Port Bridge with Track-Load Handshake

The bridge sits on the host I/O bus in front of a small floppy-disk controller model. It watches host I/O cycles at a pair of controller ports, one for status and one for data. It turns them into three things. The first is a disk-select request: a host write to the normally read-only status port names a disk image. The second is a byte stream for a command layer. The third is a status byte that the host reads back. A command layer beside it reports seeks, recalibrates and track-buffer writes. The bridge turns these into requests to a back-end track loader that holds the disk images.

The back end is driven through one request/acknowledge pair. The request is a level that stays up until a single-cycle acknowledge. It carries an operation code, a disk number and a track number. A seek that finds the track buffer dirty first asks for a flush of the current track, and only then asks for the new track to be loaded. For as long as any request is waiting or outstanding, the host sees a busy status, so it stalls until the track is really in the buffer. If the back end reports that a requested disk is missing, the active disk falls back to 0.

Top module: `fdc_port_bridge`

## Requirements
- R1: Port accesses are decoded only while `io_req` is high. A read of a port that is not selected, or a read outside an I/O cycle, returns 0xFF, and a write outside an I/O cycle has no effect.
- R2: A host write to 0xFB7E latches the data byte as a disk number. The bridge then raises `be_req` with `be_op` = 1 (disk select) and `be_disk` equal to that byte.
- R3: When the disk-select request is acknowledged with `be_absent` high, `disk_active` becomes 0. Otherwise `disk_active` becomes the requested number.
- R4: A `seek_go` pulse raises a request with `be_op` = 3 (load) and `be_track` = `seek_track`. A `seek_recal` pulse does the same with track 0. After the acknowledge, `track_now` holds the loaded track.
- R5: A status read at 0xFB7E returns 0x10 (busy, bit 7 clear) while any back-end operation is waiting or outstanding. Otherwise it returns 0x80, with bit 6 also set when `cmd_in_valid` is high.
- R6: While `be_req` is high and `be_ack` is low, `be_req`, `be_op`, `be_disk` and `be_track` stay unchanged, and no second request issues.
- R7: A `buf_wr` pulse marks the track buffer dirty. A seek on a dirty buffer first issues `be_op` = 2 (flush) with `be_track` equal to the current track, and then issues the load. A seek on a clean buffer issues the load directly.
- R8: Host writes to 0xFB7F enter a FIFO of `FIFO_DEPTH` bytes, which is read out in order through `cmd_valid`/`cmd_data`/`cmd_ready`. Writes made while the FIFO is full are dropped.
- R9: A host read of 0xFB7F returns `cmd_in_data`, and pulses `cmd_in_pop` exactly once per I/O cycle.
- R10: A write cycle held over several clocks acts only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_req | input | 1 | Host I/O cycle in progress |
| io_rd | input | 1 | Host read strobe |
| io_wr | input | 1 | Host write strobe |
| io_addr | input | 16 | Host port address |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data, combinational |
| cmd_valid | output | 1 | FIFO holds a host data-port byte |
| cmd_data | output | 8 | Oldest FIFO byte |
| cmd_ready | input | 1 | Command layer takes the byte |
| cmd_in_valid | input | 1 | Command layer has a byte for the host |
| cmd_in_data | input | 8 | Byte returned on data-port reads |
| cmd_in_pop | output | 1 | One-cycle pulse per data-port read cycle |
| seek_go | input | 1 | Seek pulse |
| seek_recal | input | 1 | Recalibrate pulse (seek to track 0) |
| seek_track | input | TRK_W | Seek target track |
| buf_wr | input | 1 | Track-buffer byte written |
| be_req | output | 1 | Back-end request level |
| be_op | output | 2 | 1 disk select, 2 flush, 3 load |
| be_disk | output | 8 | Disk number |
| be_track | output | TRK_W | Track number |
| be_ack | input | 1 | One-cycle acknowledge |
| be_absent | input | 1 | With acknowledge: disk missing |
| disk_active | output | 8 | Active disk number |
| track_now | output | TRK_W | Track held in the buffer |
| track_dirty | output | 1 | Buffer holds unflushed writes |

## Verification
The checker watches several rules on every clock. It checks that a request stays stable until it is acknowledged, and that the host status reads busy whenever a request is up. It checks that no load request opens while the buffer is dirty, that an acknowledge with absent clears the active disk, and that acknowledges come only with a request. The bench scenarios cover the rest, which needs whole sequences: the disk and track sweeps, flush-then-load ordering, FIFO order and drop-on-full, single action per long I/O cycle, and the ignoring of strobes outside an I/O cycle.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

    localparam int DATA_W = 8;
    localparam logic [15:0] PORT_STAT = 16'hFB7E;
    localparam logic [15:0] PORT_DATA = 16'hFB7F;

    localparam logic [DATA_W-1:0] ST_BUSY  = 8'h10;
    localparam logic [DATA_W-1:0] ST_READY = 8'h80;
    localparam logic [DATA_W-1:0] ST_DIO   = 8'h40;
    localparam logic [DATA_W-1:0] BUS_IDLE = 8'hFF;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_DISK  = 2'd1,
        OP_FLUSH = 2'd2,
        OP_LOAD  = 2'd3
    } be_op_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_DISK,
        SQ_FLUSH,
        SQ_LOAD
    } sq_state_t;

    typedef struct packed {
        logic stat_wr;
        logic data_wr;
        logic data_rd;
        logic stat_rd_lvl;
        logic data_rd_lvl;
    } io_hit_t;

    function automatic logic [DATA_W-1:0] status_byte(logic busy, logic dio);
        if (busy) return ST_BUSY;
        return ST_READY | (dio ? ST_DIO : '0);
    endfunction

endpackage

// File: rtl/fdc_io_decode.sv
module fdc_io_decode
    import fdc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        io_req,
    input  logic        io_rd,
    input  logic        io_wr,
    input  logic [15:0] io_addr,
    output io_hit_t     hit
);
    logic at_stat, at_data;
    logic sw_lvl, dw_lvl, dr_lvl;
    logic sw_q, dw_q, dr_q;

    assign at_stat = io_req && (io_addr == PORT_STAT);
    assign at_data = io_req && (io_addr == PORT_DATA);
    assign sw_lvl  = at_stat && io_wr;
    assign dw_lvl  = at_data && io_wr;
    assign dr_lvl  = at_data && io_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_q <= 1'b0;
            dw_q <= 1'b0;
            dr_q <= 1'b0;
        end else begin
            sw_q <= sw_lvl;
            dw_q <= dw_lvl;
            dr_q <= dr_lvl;
        end
    end

    always_comb begin
        hit.stat_wr     = sw_lvl && !sw_q;
        hit.data_wr     = dw_lvl && !dw_q;
        hit.data_rd     = dr_lvl && !dr_q;
        hit.stat_rd_lvl = at_stat && io_rd;
        hit.data_rd_lvl = dr_lvl;
    end
endmodule

// File: rtl/fdc_byte_fifo.sv
module fdc_byte_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic         valid,
    output logic [W-1:0] dout
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign valid   = (cnt != '0);
    assign dout    = mem[rp];
    assign do_pop  = pop && valid;
    assign do_push = push && (cnt != FULL);

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/fdc_track_seq.sv
module fdc_track_seq
    import fdc_pkg::*;
#(
    parameter int TRK_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              disk_wr,
    input  logic [DATA_W-1:0] disk_num,
    input  logic              seek_go,
    input  logic              seek_recal,
    input  logic [TRK_W-1:0]  seek_track,
    input  logic              buf_wr,
    input  logic              be_ack,
    input  logic              be_absent,
    output logic              be_req,
    output be_op_t            be_op,
    output logic [DATA_W-1:0] be_disk,
    output logic [TRK_W-1:0]  be_track,
    output logic              busy,
    output logic [DATA_W-1:0] disk_act,
    output logic [TRK_W-1:0]  trk_cur,
    output logic              dirty
);
    sq_state_t         state;
    logic              disk_pend, seek_pend;
    logic [DATA_W-1:0] disk_next, disk_fly;
    logic [TRK_W-1:0]  trk_tgt, trk_fly;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            disk_pend <= 1'b0;
            seek_pend <= 1'b0;
            disk_next <= '0;
            disk_fly  <= '0;
            disk_act  <= '0;
            trk_tgt   <= '0;
            trk_fly   <= '0;
            trk_cur   <= '0;
            dirty     <= 1'b0;
        end else begin
            if (buf_wr) dirty <= 1'b1;

            unique case (state)
                SQ_IDLE: begin
                    if (disk_pend) begin
                        disk_fly  <= disk_next;
                        disk_pend <= 1'b0;
                        state     <= SQ_DISK;
                    end else if (seek_pend) begin
                        trk_fly   <= trk_tgt;
                        seek_pend <= 1'b0;
                        state     <= dirty ? SQ_FLUSH : SQ_LOAD;
                    end
                end
                SQ_DISK: begin
                    if (be_ack) begin
                        disk_act <= be_absent ? '0 : disk_fly;
                        state    <= SQ_IDLE;
                    end
                end
                SQ_FLUSH: begin
                    if (be_ack) begin
                        dirty <= 1'b0;
                        state <= SQ_LOAD;
                    end
                end
                SQ_LOAD: begin
                    if (be_ack) begin
                        trk_cur <= trk_fly;
                        state   <= SQ_IDLE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase

            if (disk_wr) begin
                disk_next <= disk_num;
                disk_pend <= 1'b1;
            end
            if (seek_go || seek_recal) begin
                trk_tgt   <= seek_recal ? '0 : seek_track;
                seek_pend <= 1'b1;
            end
        end
    end

    always_comb begin
        be_req   = (state != SQ_IDLE);
        be_disk  = (state == SQ_DISK) ? disk_fly : disk_act;
        be_track = (state == SQ_FLUSH) ? trk_cur : trk_fly;
        busy     = be_req || disk_pend || seek_pend;
        unique case (state)
            SQ_DISK:  be_op = OP_DISK;
            SQ_FLUSH: be_op = OP_FLUSH;
            SQ_LOAD:  be_op = OP_LOAD;
            default:  be_op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/fdc_port_bridge.sv
module fdc_port_bridge
    import fdc_pkg::*;
#(
    parameter int TRK_W      = 8,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_req,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [15:0]       io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              cmd_valid,
    output logic [DATA_W-1:0] cmd_data,
    input  logic              cmd_ready,
    input  logic              cmd_in_valid,
    input  logic [DATA_W-1:0] cmd_in_data,
    output logic              cmd_in_pop,
    input  logic              seek_go,
    input  logic              seek_recal,
    input  logic [TRK_W-1:0]  seek_track,
    input  logic              buf_wr,
    output logic              be_req,
    output logic [1:0]        be_op,
    output logic [DATA_W-1:0] be_disk,
    output logic [TRK_W-1:0]  be_track,
    input  logic              be_ack,
    input  logic              be_absent,
    output logic [DATA_W-1:0] disk_active,
    output logic [TRK_W-1:0]  track_now,
    output logic              track_dirty
);
    io_hit_t           hit;
    be_op_t            op_e;
    logic              busy;
    logic [DATA_W-1:0] stat_now;

    fdc_io_decode u_dec (
        .clk     (clk),
        .rst     (rst),
        .io_req  (io_req),
        .io_rd   (io_rd),
        .io_wr   (io_wr),
        .io_addr (io_addr),
        .hit     (hit)
    );

    fdc_byte_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (hit.data_wr),
        .din   (io_wdata),
        .pop   (cmd_ready),
        .valid (cmd_valid),
        .dout  (cmd_data)
    );

    fdc_track_seq #(.TRK_W(TRK_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .disk_wr    (hit.stat_wr),
        .disk_num   (io_wdata),
        .seek_go    (seek_go),
        .seek_recal (seek_recal),
        .seek_track (seek_track),
        .buf_wr     (buf_wr),
        .be_ack     (be_ack),
        .be_absent  (be_absent),
        .be_req     (be_req),
        .be_op      (op_e),
        .be_disk    (be_disk),
        .be_track   (be_track),
        .busy       (busy),
        .disk_act   (disk_active),
        .trk_cur    (track_now),
        .dirty      (track_dirty)
    );

    assign be_op      = op_e;
    assign cmd_in_pop = hit.data_rd;
    assign stat_now   = status_byte(busy, cmd_in_valid);

    always_comb begin
        if (hit.stat_rd_lvl)      io_rdata = stat_now;
        else if (hit.data_rd_lvl) io_rdata = cmd_in_data;
        else                      io_rdata = BUS_IDLE;
    end
endmodule

// File: rtl/fdc_port_bridge_checker.sv
module fdc_port_bridge_checker
    import fdc_pkg::*;
#(
    parameter int TRK_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              be_req,
    input logic [1:0]        be_op,
    input logic [DATA_W-1:0] be_disk,
    input logic [TRK_W-1:0]  be_track,
    input logic              be_ack,
    input logic              be_absent,
    input logic [DATA_W-1:0] disk_active,
    input logic              track_dirty,
    input logic [DATA_W-1:0] stat_now
);
    p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (be_req && !be_ack) |=> (be_req && $stable(be_op) && $stable(be_disk) && $stable(be_track)));

    p_busy_status_r5: assert property (@(posedge clk) disable iff (rst)
        be_req |-> (stat_now == ST_BUSY));

    p_flush_first_r7: assert property (@(posedge clk) disable iff (rst)
        (be_op == OP_LOAD && $past(be_op) != OP_LOAD) |-> !track_dirty);

    p_absent_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (be_ack && be_absent && be_op == OP_DISK) |=> (disk_active == '0));

    p_ack_has_req_r6: assert property (@(posedge clk) disable iff (rst)
        be_ack |-> be_req);
endmodule

bind fdc_port_bridge fdc_port_bridge_checker #(.TRK_W(TRK_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .be_req      (be_req),
    .be_op       (be_op),
    .be_disk     (be_disk),
    .be_track    (be_track),
    .be_ack      (be_ack),
    .be_absent   (be_absent),
    .disk_active (disk_active),
    .track_dirty (track_dirty),
    .stat_now    (stat_now)
);

// File: tb/fdc_port_bridge_bench.sv
module fdc_port_bridge_bench;
    localparam int TRK_W = 8;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_req = 0, io_rd = 0, io_wr = 0;
    logic [15:0] io_addr = 16'h0000;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic        cmd_valid, cmd_ready = 0, cmd_in_valid = 0, cmd_in_pop;
    logic [7:0]  cmd_data, cmd_in_data = 8'h00;
    logic        seek_go = 0, seek_recal = 0, buf_wr = 0;
    logic [TRK_W-1:0] seek_track = '0;
    logic        be_req, be_ack = 0, be_absent = 0;
    logic [1:0]  be_op;
    logic [7:0]  be_disk, disk_active;
    logic [TRK_W-1:0] be_track, track_now;
    logic        track_dirty;

    int n_chk = 0;
    int n_fail = 0;
    int pops = 0;

    always #10 clk = ~clk;

    always @(posedge clk) if (cmd_in_pop) pops++;

    fdc_port_bridge #(.TRK_W(TRK_W), .FIFO_DEPTH(DEPTH)) u_fdc_port_bridge (
        .clk(clk), .rst(rst),
        .io_req(io_req), .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
        .cmd_in_valid(cmd_in_valid), .cmd_in_data(cmd_in_data), .cmd_in_pop(cmd_in_pop),
        .seek_go(seek_go), .seek_recal(seek_recal), .seek_track(seek_track),
        .buf_wr(buf_wr),
        .be_req(be_req), .be_op(be_op), .be_disk(be_disk), .be_track(be_track),
        .be_ack(be_ack), .be_absent(be_absent),
        .disk_active(disk_active), .track_now(track_now), .track_dirty(track_dirty)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d, input int hold);
        @(negedge clk);
        io_req = 1; io_wr = 1; io_addr = a; io_wdata = d;
        repeat (hold) @(negedge clk);
        io_req = 0; io_wr = 0;
    endtask

    task automatic stat_read(input string tag, input int exp);
        @(negedge clk);
        io_req = 1; io_rd = 1; io_addr = 16'hFB7E;
        #2 chk(tag, io_rdata, exp);
        @(negedge clk);
        io_req = 0; io_rd = 0;
    endtask

    task automatic serve(input string tag, input int op, input int val,
                         input logic absent, input int gap);
        int w = 0;
        while (!be_req && w < 200) begin @(negedge clk); w++; end
        chk({tag, " op"}, be_op, op);
        chk({tag, " value"}, (op == 1) ? be_disk : be_track, val);
        stat_read("R5 busy while request up", 8'h10);
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            chk("R6 request held", {be_req, be_op}, {1'b1, op[1:0]});
        end
        be_ack = 1; be_absent = absent;
        @(negedge clk);
        be_ack = 0; be_absent = 0;
    endtask

    task automatic pulse_seek(input int t, input logic recal);
        @(negedge clk);
        seek_track = TRK_W'(t);
        seek_go = !recal; seek_recal = recal;
        @(negedge clk);
        seek_go = 0; seek_recal = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R2 reset no request", be_req, 0);
        chk("R3 reset disk", disk_active, 0);
        chk("R8 reset fifo empty", cmd_valid, 0);
        chk("R1 idle bus", io_rdata, 8'hFF);
        stat_read("R5 ready at reset", 8'h80);

        // R1: strobes outside an I/O cycle
        @(negedge clk);
        io_wr = 1; io_addr = 16'hFB7E; io_wdata = 8'h07;
        repeat (4) @(negedge clk);
        io_wr = 0;
        io_addr = 16'hFB7F; io_wr = 1; io_wdata = 8'h33;
        repeat (2) @(negedge clk);
        io_wr = 0;
        repeat (3) @(negedge clk);
        chk("R1 no request from memory cycle", be_req, 0);
        chk("R1 no fifo push from memory cycle", cmd_valid, 0);
        stat_read("R1 status still ready", 8'h80);

        // R2/R3/R10: disk sweep, every third disk absent
        for (int d = 1; d <= 9; d++) begin
            logic ab = (d % 3 == 0);
            io_write(16'hFB7E, 8'(d), 5);
            serve("R2 disk select", 1, d, ab, 2);
            chk("R3 active disk", disk_active, ab ? 0 : d);
            repeat (3) @(negedge clk);
            chk("R10 single action per cycle", be_req, 0);
        end

        // R4: track sweep on a clean buffer
        for (int t = 0; t < 40; t++) begin
            pulse_seek((t * 7) % 80, 1'b0);
            serve("R4 load", 3, (t * 7) % 80, 1'b0, t % 3);
            chk("R4 track now", track_now, (t * 7) % 80);
        end
        pulse_seek(33, 1'b1);
        serve("R4 recal load", 3, 0, 1'b0, 1);
        chk("R4 recal track", track_now, 0);

        // R7: flush before load
        pulse_seek(12, 1'b0);
        serve("R7 clean load", 3, 12, 1'b0, 0);
        @(negedge clk); buf_wr = 1; @(negedge clk); buf_wr = 0;
        chk("R7 dirty set", track_dirty, 1);
        pulse_seek(20, 1'b0);
        serve("R7 flush first", 2, 12, 1'b0, 2);
        chk("R7 dirty cleared", track_dirty, 0);
        serve("R7 then load", 3, 20, 1'b0, 1);
        chk("R7 new track", track_now, 20);
        pulse_seek(21, 1'b0);
        serve("R7 clean seek no flush", 3, 21, 1'b0, 0);

        // R8: FIFO order and drop on full
        for (int i = 0; i < DEPTH + 1; i++) io_write(16'hFB7F, 8'(8'hA0 + i), 3);
        @(negedge clk);
        chk("R8 fifo valid", cmd_valid, 1);
        cmd_ready = 1;
        for (int i = 0; i < DEPTH; i++) begin
            chk("R8 fifo order", cmd_data, 8'hA0 + i);
            @(negedge clk);
        end
        cmd_ready = 0;
        chk("R8 extra byte dropped", cmd_valid, 0);

        // R9/R5: data read and data-direction bit
        cmd_in_valid = 1; cmd_in_data = 8'h5A;
        stat_read("R5 ready with host byte", 8'hC0);
        pops = 0;
        @(negedge clk);
        io_req = 1; io_rd = 1; io_addr = 16'hFB7F;
        #2 chk("R9 data read value", io_rdata, 8'h5A);
        repeat (4) @(negedge clk);
        io_req = 0; io_rd = 0;
        @(negedge clk);
        chk("R9 one pop per cycle", pops, 1);
        cmd_in_valid = 0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule